// File: doc/BRIEF.md
# Per-Vector Interrupt Cause Array

This block keeps one byte-wide cause register for every interrupt vector of a network interface, for use when automatic vector masking is switched off. A byte holding zero means its vector is armed. When the device side reports an event (vector index plus a nonzero cause code), an armed vector takes the code into its byte and requests one interrupt message. Writing the code also masks the vector. Code 1 stands for receive/transmit ring activity and code 2 for a change of link state. The host re-arms a vector by writing zero to its byte.

An event that reaches a vector which is already masked sends no message. It is kept as pending, and the newest pending code replaces any older one. When the host later clears the byte, the pending code moves into the byte and a message is requested. The host reaches the bytes through a 32-bit register port placed at a base offset. Each word holds four consecutive vectors, and byte-lane strobes select which of them a write touches. An automatic-masking input bypasses the array: while it is high, every event requests a message at once and no byte changes.

Each vector runs a three-state machine:
- ARMED: the byte is zero.
- HELD: the byte is nonzero and nothing is pending.
- HELD_PEND: the byte is nonzero and one event is waiting.

Its transitions are:
- ARMED to HELD on an event (message) or on a host write of a nonzero value.
- HELD to ARMED on a host clear.
- HELD to HELD_PEND on an event.
- HELD_PEND to HELD on a host clear, which releases the pending code and sends a message.
- HELD or HELD_PEND to HELD on an event that lands in the same cycle as a host clear, which sends a message with the new code.

Top module: `irq_cause_array`

## Requirements
- R1: After reset every cause byte is zero, no vector is masked, no message request is raised and the read data is zero.
- R2: With automatic masking off, an event with a nonzero code on an armed vector stores the code in that vector's byte and masks the vector. The matching msg_req_o bit is high for exactly the one cycle after the event's clock edge.
- R3: An event on a masked vector raises no message. It is held as pending, and a later event on the same masked vector replaces the pending code.
- R4: A host write of zero to a masked vector with nothing pending makes the vector armed, with no message. If an event is pending, the byte takes the pending code instead, the vector stays masked and one message is requested.
- R5: When an event and a host zero-write reach the same masked vector in the same cycle, the event wins: the byte takes the new code, the vector stays masked and one message is requested.
- R6: A write to byte address BASE_ADDR+4w updates vector 4w+k from write-data bits [8k+7:8k] only where strobe bit k is set. A nonzero value masks the vector.
- R7: A read returns the word at BASE_ADDR+4w, with vector 4w+k in bits [8k+7:8k]. The data appears on host_rdata_o one cycle after the read and holds until the next read.
- R8: Addresses outside BASE_ADDR to BASE_ADDR+NUM_VEC-1 read as zero and writes to them change no vector.
- R9: An event whose cause code is zero has no effect.
- R10: With automatic masking on, each event with a nonzero code raises the vector's msg_req_o bit in the next cycle and leaves all cause bytes unchanged.
- R11: masked_o for a vector is high exactly when its cause byte is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mask_i | input | 1 | Automatic masking on: events bypass the array |
| evt_valid_i | input | 1 | Device event strobe |
| evt_vec_i | input | VEC_W | Vector index of the event |
| evt_code_i | input | 8 | Cause code of the event (1 ring activity, 2 link change) |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wstrb_i | input | 4 | Byte-lane write enables |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered host read data |
| msg_req_o | output | NUM_VEC | One-cycle interrupt message request per vector |
| masked_o | output | NUM_VEC | Per-vector mask state |

## Verification
A device event and a host write of zero can reach the same vector in one cycle, and each would steer that vector's state machine in a different direction. The bench places both on vector 5 in a single stimulus step and expects the event to win: a message in the next cycle, the vector still masked, and a later read returning the event's code rather than zero. A second overlap comes from a host clear that meets a pending event. In that case the released pending code must appear in the byte read back, together with exactly one message.

// File: rtl/ict_pkg.sv
package ict_pkg;
    localparam int CODE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        ST_ARMED     = 2'd0,
        ST_HELD      = 2'd1,
        ST_HELD_PEND = 2'd2
    } vec_state_e;
endpackage

// File: rtl/ict_vec_cell.sv
module ict_vec_cell
    import ict_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_i,
    input  logic              evt_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wr_byte_i,
    output logic [CODE_W-1:0] code_o,
    output logic              msg_o,
    output logic              masked_o
);
    vec_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] pend_q, pend_d;
    logic              msg_q, msg_d;
    logic              evt_live, evt_gated, clr_req, set_req;

    assign evt_live  = evt_i && (evt_code_i != '0);
    assign evt_gated = evt_live && !auto_i;
    assign clr_req   = wr_i && (wr_byte_i == '0);
    assign set_req   = wr_i && (wr_byte_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            code_q  <= '0;
            pend_q  <= '0;
            msg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            pend_q  <= pend_d;
            msg_q   <= msg_d;
        end
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        pend_d  = pend_q;
        msg_d   = evt_live && auto_i;
        unique case (state_q)
            ST_ARMED: begin
                if (evt_gated) begin
                    code_d  = evt_code_i;
                    msg_d   = 1'b1;
                    state_d = ST_HELD;
                end else if (set_req) begin
                    code_d  = wr_byte_i;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (clr_req && evt_gated) begin
                    code_d = evt_code_i;
                    msg_d  = 1'b1;
                end else if (clr_req) begin
                    code_d  = '0;
                    state_d = ST_ARMED;
                end else begin
                    if (set_req) code_d = wr_byte_i;
                    if (evt_gated) begin
                        pend_d  = evt_code_i;
                        state_d = ST_HELD_PEND;
                    end
                end
            end
            ST_HELD_PEND: begin
                if (clr_req) begin
                    code_d  = evt_gated ? evt_code_i : pend_q;
                    pend_d  = '0;
                    msg_d   = 1'b1;
                    state_d = ST_HELD;
                end else begin
                    if (set_req) code_d = wr_byte_i;
                    if (evt_gated) pend_d = evt_code_i;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    assign code_o   = code_q;
    assign msg_o    = msg_q;
    assign masked_o = (state_q != ST_ARMED);

    AST_ARMED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_i && evt_live && !masked_o) |=> (msg_o && masked_o)); // R2
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_i && masked_o && evt_i && !clr_req) |=> !msg_o); // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_i && masked_o && evt_live && clr_req) |=> (msg_o && code_o == $past(evt_code_i))); // R5
    AST_ZERO_CODE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && evt_code_i == '0 && !wr_i) |=> (!msg_o && $stable(code_o))); // R9
    AST_AUTO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && evt_live) |=> msg_o); // R10
    AST_AUTO_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && !wr_i) |=> $stable(code_o)); // R10
    AST_MASK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        masked_o == (code_o != '0)); // R11
endmodule

// File: rtl/ict_host_port.sv
module ict_host_port
    import ict_pkg::*;
#(
    parameter int NUM_VEC   = 32,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h0C00,
    localparam int DATA_W   = LANES * CODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      wr_i,
    input  logic                      rd_i,
    input  logic [LANES-1:0]          wstrb_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NUM_VEC*CODE_W-1:0] codes_i,
    output logic [NUM_VEC-1:0]        vec_wr_o,
    output logic [NUM_VEC*CODE_W-1:0] vec_wdata_o,
    output logic [DATA_W-1:0]         rdata_o
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_VEC);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-3:0] word_idx;
    logic              hit;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    assign offset   = addr_i - BASE;
    assign word_idx = offset[ADDR_W-1:2];
    assign hit      = (addr_i >= BASE) && (offset < SPAN);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_lane
        assign vec_wr_o[v] = wr_i && hit && (word_idx == (ADDR_W-2)'(v / LANES))
                             && wstrb_i[v % LANES];
        assign vec_wdata_o[v*CODE_W +: CODE_W] = wdata_i[(v % LANES)*CODE_W +: CODE_W];
    end

    always_comb begin
        rd_word = '0;
        if (hit) begin
            for (int lane = 0; lane < LANES; lane++) begin
                if (int'(word_idx) * LANES + lane < NUM_VEC)
                    rd_word[lane*CODE_W +: CODE_W] =
                        codes_i[(int'(word_idx) * LANES + lane)*CODE_W +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_word;
    end

    assign rdata_o = rdata_q;

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !hit) |=> (rdata_o == '0)); // R8
    AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (vec_wr_o == '0)); // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o)); // R7
endmodule

// File: rtl/irq_cause_array.sv
module irq_cause_array
    import ict_pkg::*;
#(
    parameter int NUM_VEC   = 32,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h0C00,
    localparam int VEC_W    = $clog2(NUM_VEC),
    localparam int DATA_W   = LANES * CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_mask_i,
    input  logic               evt_valid_i,
    input  logic [VEC_W-1:0]   evt_vec_i,
    input  logic [CODE_W-1:0]  evt_code_i,
    input  logic [ADDR_W-1:0]  host_addr_i,
    input  logic               host_wr_i,
    input  logic               host_rd_i,
    input  logic [LANES-1:0]   host_wstrb_i,
    input  logic [DATA_W-1:0]  host_wdata_i,
    output logic [DATA_W-1:0]  host_rdata_o,
    output logic [NUM_VEC-1:0] msg_req_o,
    output logic [NUM_VEC-1:0] masked_o
);
    logic [NUM_VEC*CODE_W-1:0] codes;
    logic [NUM_VEC*CODE_W-1:0] vec_wdata;
    logic [NUM_VEC-1:0]        vec_wr;

    ict_host_port #(
        .NUM_VEC  (NUM_VEC),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (host_addr_i),
        .wr_i       (host_wr_i),
        .rd_i       (host_rd_i),
        .wstrb_i    (host_wstrb_i),
        .wdata_i    (host_wdata_i),
        .codes_i    (codes),
        .vec_wr_o   (vec_wr),
        .vec_wdata_o(vec_wdata),
        .rdata_o    (host_rdata_o)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        ict_vec_cell i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .auto_i    (auto_mask_i),
            .evt_i     (evt_valid_i && (evt_vec_i == VEC_W'(v))),
            .evt_code_i(evt_code_i),
            .wr_i      (vec_wr[v]),
            .wr_byte_i (vec_wdata[v*CODE_W +: CODE_W]),
            .code_o    (codes[v*CODE_W +: CODE_W]),
            .msg_o     (msg_req_o[v]),
            .masked_o  (masked_o[v])
        );
    end

    AST_SINGLE_EVENT_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !host_wr_i) |=> ($countones(msg_req_o) <= 1)); // R2
endmodule

// File: tb/test_irq_cause_array.sv
`timescale 1ns/1ps
module test_irq_cause_array;
    localparam int NUM_VEC = 32;
    localparam int VEC_W   = 5;
    localparam logic [15:0] BASE = 16'h0C00;

    typedef struct packed {
        logic [1:0]  kind;   // 0 event, 1 write, 2 read, 3 event+write
        logic [7:0]  vec;
        logic [7:0]  code;
        logic [31:0] wd;
        logic [3:0]  strb;
        logic        xmsg;
        logic        xmask;
        logic [31:0] xrd;
    } step_t;

    localparam int NSTEP = 19;
    localparam step_t TBL [NSTEP] = '{
        '{2'd0, 8'd3,  8'd1, 32'h0,        4'h0, 1'b1, 1'b1, 32'h0},        // R2 fire, code 1
        '{2'd0, 8'd3,  8'd2, 32'h0,        4'h0, 1'b0, 1'b1, 32'h0},        // R3 pend
        '{2'd2, 8'd3,  8'd0, 32'h0,        4'h0, 1'b0, 1'b1, 32'h01000000}, // R7 lane 3
        '{2'd1, 8'd3,  8'd0, 32'h0,        4'h8, 1'b1, 1'b1, 32'h0},        // R4 release
        '{2'd2, 8'd3,  8'd0, 32'h0,        4'h0, 1'b0, 1'b1, 32'h02000000}, // R4 pending code
        '{2'd1, 8'd3,  8'd0, 32'h0,        4'h8, 1'b0, 1'b0, 32'h0},        // R4 re-arm
        '{2'd0, 8'd5,  8'd2, 32'h0,        4'h0, 1'b1, 1'b1, 32'h0},        // R2 code 2
        '{2'd3, 8'd5,  8'd1, 32'h0,        4'h2, 1'b1, 1'b1, 32'h0},        // R5 event wins
        '{2'd2, 8'd5,  8'd0, 32'h0,        4'h0, 1'b0, 1'b1, 32'h00000100}, // R5 byte holds new code
        '{2'd1, 8'd5,  8'd0, 32'h44332211, 4'hF, 1'b0, 1'b1, 32'h0},        // R6 full word
        '{2'd2, 8'd4,  8'd0, 32'h0,        4'h0, 1'b0, 1'b1, 32'h44332211}, // R6 readback
        '{2'd1, 8'd4,  8'd0, 32'h0,        4'h5, 1'b0, 1'b0, 32'h0},        // R6 lanes 0,2
        '{2'd2, 8'd5,  8'd0, 32'h0,        4'h0, 1'b0, 1'b1, 32'h44002200}, // R6 other lanes kept
        '{2'd0, 8'd0,  8'd0, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},        // R9 zero code
        '{2'd2, 8'd0,  8'd0, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},        // R9 byte unchanged
        '{2'd1, 8'd32, 8'd0, 32'hFFFFFFFF, 4'hF, 1'b0, 1'b0, 32'h0},        // R8 write beyond span
        '{2'd2, 8'd32, 8'd0, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},        // R8 read beyond span
        '{2'd2, 8'd0,  8'd0, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},        // R8 no aliasing
        '{2'd2, 8'd64, 8'd0, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0}         // R8 far address
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               auto_mask = 1'b0;
    logic               evt_valid = 1'b0;
    logic [VEC_W-1:0]   evt_vec = '0;
    logic [7:0]         evt_code = '0;
    logic [15:0]        host_addr = '0;
    logic               host_wr = 1'b0;
    logic               host_rd = 1'b0;
    logic [3:0]         host_wstrb = '0;
    logic [31:0]        host_wdata = '0;
    logic [31:0]        host_rdata;
    logic [NUM_VEC-1:0] msg_req;
    logic [NUM_VEC-1:0] masked;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    irq_cause_array #(.NUM_VEC(NUM_VEC)) i_irq_cause_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mask_i (auto_mask),
        .evt_valid_i (evt_valid),
        .evt_vec_i   (evt_vec),
        .evt_code_i  (evt_code),
        .host_addr_i (host_addr),
        .host_wr_i   (host_wr),
        .host_rd_i   (host_rd),
        .host_wstrb_i(host_wstrb),
        .host_wdata_i(host_wdata),
        .host_rdata_o(host_rdata),
        .msg_req_o   (msg_req),
        .masked_o    (masked)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_step(input step_t s, input string tag);
        evt_valid  = (s.kind == 2'd0) || (s.kind == 2'd3);
        evt_vec    = s.vec[VEC_W-1:0];
        evt_code   = s.code;
        host_wr    = (s.kind == 2'd1) || (s.kind == 2'd3);
        host_rd    = (s.kind == 2'd2);
        host_addr  = BASE + {6'd0, s.vec[7:2], 2'b00};
        host_wstrb = s.strb;
        host_wdata = s.wd;
        @(negedge clk);
        evt_valid = 1'b0;
        host_wr   = 1'b0;
        host_rd   = 1'b0;
        if (s.vec < NUM_VEC) begin
            chk(msg_req[s.vec] == s.xmsg, {tag, " msg"}, 32'(msg_req[s.vec]), 32'(s.xmsg));
            chk(masked[s.vec] == s.xmask, {tag, " masked"}, 32'(masked[s.vec]), 32'(s.xmask));
        end
        if (s.kind == 2'd2)
            chk(host_rdata == s.xrd, {tag, " rdata"}, host_rdata, s.xrd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(masked == '0, "R1 masked", masked, 32'h0);
        chk(msg_req == '0, "R1 msg", msg_req, 32'h0);
        chk(host_rdata == '0, "R1 rdata", host_rdata, 32'h0);

        for (int i = 0; i < NSTEP; i++)
            run_step(TBL[i], $sformatf("table step %0d", i));

        // R10 automatic masking bypass
        auto_mask = 1'b1;
        run_step('{2'd0, 8'd9, 8'd1, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0}, "R10 armed bypass");
        run_step('{2'd0, 8'd5, 8'd2, 32'h0, 4'h0, 1'b1, 1'b1, 32'h0}, "R10 masked bypass");
        run_step('{2'd2, 8'd5, 8'd0, 32'h0, 4'h0, 1'b0, 1'b1, 32'h44002200}, "R10 bytes kept");
        auto_mask = 1'b0;

        // R3 newest pending code replaces older one
        run_step('{2'd0, 8'd10, 8'd1, 32'h0, 4'h0, 1'b1, 1'b1, 32'h0}, "R3 first fire");
        run_step('{2'd0, 8'd10, 8'd2, 32'h0, 4'h0, 1'b0, 1'b1, 32'h0}, "R3 pend a");
        run_step('{2'd0, 8'd10, 8'd1, 32'h0, 4'h0, 1'b0, 1'b1, 32'h0}, "R3 pend b");
        run_step('{2'd1, 8'd10, 8'd0, 32'h0, 4'h4, 1'b1, 1'b1, 32'h0}, "R3 release");
        run_step('{2'd2, 8'd10, 8'd0, 32'h0, 4'h0, 1'b0, 1'b1, 32'h00010000}, "R3 newest code");

        // R2 message is a single-cycle pulse
        chk(msg_req == '0, "R2 pulse ends", msg_req, 32'h0);
        // R11 mask mirrors nonzero bytes: vectors 5, 7, 10 hold codes
        chk(masked == 32'h000004A0, "R11 mask set", masked, 32'h000004A0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule